// File: doc/BRIEF.md
# AC-link Control and Power Register

This block is the control register that sits in front of an AC-link audio codec port. Software turns on individual control bits by writing ones to an enable address. It turns them off by writing ones to a separate disable address. A zero written to either address leaves the matching bits alone. The register bits drive the link-side controls directly:

- the active-low codec reset;
- a warm reset request to the link logic;
- a low-power override that holds the frame sync and serial output lines low;
- a wake-up detector on the two serial inputs;
- the choice of receive slot.

The block also keeps one sticky ready flag per codec. Each flag is set by the frame logic. Software clears both flags through a write-only action bit. The frame generator, the slot data path and the interrupt controller lie outside this block. The block only gates the frame generator's sync and data-out signals and raises a level wake request toward the interrupt controller.

Reads are combinational from the bus address. A write takes effect at the clock edge that samples it.

Top module: `aclink_ctrl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every control bit and both ready flags become 0. Afterwards `link_reset_n`=0, `warm_reset`=0, `rx_mic_sel`=0, and the sync and data-out lines pass through unchanged.
- R2: A write to address 0 sets each of control bits 4..0 whose data bit is 1 and leaves the others unchanged. The new state reads back at address 0 (bit 0 link enable, bit 1 low power, bit 2 wake enable, bit 3 warm reset, bit 4 mic select) from the cycle after the write.
- R3: A write to address 1 clears each of control bits 4..0 whose data bit is 1 and leaves the others unchanged.
- R4: Read data bits 7..5 at address 0 are always 0. This includes right after a write with bit 5 set.
- R5: Each codec ready flag (read at address 2, bit 0 = codec 0, bit 1 = codec 1) is set by a high `codec_rdy_in` bit and stays set. A write to address 0 with data bit 5 at 1 clears both flags at that edge, and the clear wins over a ready input high in the same cycle. With data bit 5 at 0 the flags are untouched.
- R6: `link_reset_n` equals control bit 0, so the codec stays in reset while bit 0 is 0.
- R7: While control bit 1 is 1, `sync_out` and `sdout_out` are 0. Otherwise they follow `sync_in` and `sdout_in` in the same cycle.
- R8: `rx_mic_sel` equals control bit 4: 0 selects PCM slots 3 and 4, 1 selects slot 6.
- R9: `warm_reset` equals control bit 3.
- R10: `wake_irq` is high exactly while control bit 2 is 1 and at least one `sdin` line is high. It is a level that follows `sdin` in the same cycle.
- R11: Writes to any address other than 0 and 1 change no control bit. Reads from addresses other than 0 and 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| sync_in | input | 1 | Frame sync from the frame generator |
| sdout_in | input | 1 | Serial output data from the frame generator |
| sync_out | output | 1 | Frame sync to the link |
| sdout_out | output | 1 | Serial output data to the link |
| sdin | input | 2 | Serial input lines from the codecs |
| codec_rdy_in | input | 2 | Ready indications from the frame logic |
| link_reset_n | output | 1 | Active-low codec reset |
| warm_reset | output | 1 | Warm reset request |
| rx_mic_sel | output | 1 | Receive slot select |
| wake_irq | output | 1 | Level wake request |

## Verification
Every control bit drives a port with no further register. A wrong bit therefore shows on `link_reset_n`, `warm_reset`, `rx_mic_sel`, the gated sync/data lines or `wake_irq` in the cycle right after the bad write, and on the address 0 read in that same cycle. A ready flag that fails to clear, or one that loses a same-cycle race against its input, reads back wrong at address 2 one cycle later. A decode fault that lets a write at another address through shows as a changed control port after that write.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int DATA_W   = 8;
  localparam int CTL_W    = 5;
  localparam int N_CODEC  = 2;
  localparam int N_SDIN   = 2;

  localparam int B_LINK   = 0;
  localparam int B_LOWPWR = 1;
  localparam int B_WAKE   = 2;
  localparam int B_WARM   = 3;
  localparam int B_MIC    = 4;
  localparam int B_RDYCLR = 5;

  typedef logic [CTL_W-1:0] ctl_t;

  function automatic ctl_t ctl_field(input logic [DATA_W-1:0] d);
    return d[CTL_W-1:0];
  endfunction

  function automatic ctl_t apply_set_clr(input ctl_t cur, input ctl_t set_m, input ctl_t clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  function automatic logic wake_level(input logic en, input logic [N_SDIN-1:0] lines);
    return en & (|lines);
  endfunction

  function automatic logic force_low(input logic force_en, input logic v);
    return v & ~force_en;
  endfunction
endpackage

// File: rtl/aclink_ctl_bits.sv
module aclink_ctl_bits
  import aclink_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t set_mask,
  input  ctl_t clr_mask,
  output ctl_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= apply_set_clr(q, set_mask, clr_mask);
  end
endmodule

// File: rtl/aclink_rdy_flags.sv
module aclink_rdy_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rdy_in,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)   q[g] <= 1'b0;
      else if (rdy_in[g]) q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/aclink_wake_det.sv
module aclink_wake_det
  import aclink_pkg::*;
(
  input  logic              en,
  input  logic [N_SDIN-1:0] lines,
  output logic              irq
);
  assign irq = wake_level(en, lines);
endmodule

// File: rtl/aclink_link_gate.sv
module aclink_link_gate
  import aclink_pkg::*;
(
  input  logic lowpwr,
  input  logic sync_in,
  input  logic sdout_in,
  output logic sync_out,
  output logic sdout_out
);
  assign sync_out  = force_low(lowpwr, sync_in);
  assign sdout_out = force_low(lowpwr, sdout_in);
endmodule

// File: rtl/aclink_ctrl_reg.sv
module aclink_ctrl_reg
  import aclink_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int A_EN   = 0,
  parameter int A_DIS  = 1,
  parameter int A_RDY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sync_in,
  input  logic              sdout_in,
  output logic              sync_out,
  output logic              sdout_out,
  input  logic [N_SDIN-1:0] sdin,
  input  logic [N_CODEC-1:0] codec_rdy_in,
  output logic              link_reset_n,
  output logic              warm_reset,
  output logic              rx_mic_sel,
  output logic              wake_irq
);
  localparam logic [ADDR_W-1:0] AD_EN  = ADDR_W'(A_EN);
  localparam logic [ADDR_W-1:0] AD_DIS = ADDR_W'(A_DIS);
  localparam logic [ADDR_W-1:0] AD_RDY = ADDR_W'(A_RDY);

  logic wr_en_hit, wr_dis_hit, rdy_clr_pulse;
  ctl_t set_mask, clr_mask, ctl_q;
  logic [N_CODEC-1:0] rdy_q;

  assign wr_en_hit     = bus_we && (bus_addr == AD_EN);
  assign wr_dis_hit    = bus_we && (bus_addr == AD_DIS);
  assign set_mask      = wr_en_hit  ? ctl_field(bus_wdata) : '0;
  assign clr_mask      = wr_dis_hit ? ctl_field(bus_wdata) : '0;
  assign rdy_clr_pulse = wr_en_hit && bus_wdata[B_RDYCLR];

  aclink_ctl_bits u_bits (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .q(ctl_q)
  );

  aclink_rdy_flags #(.N(N_CODEC)) u_rdy (
    .clk(clk), .rst(rst), .rdy_in(codec_rdy_in), .clr(rdy_clr_pulse), .q(rdy_q)
  );

  aclink_wake_det u_wake (
    .en(ctl_q[B_WAKE]), .lines(sdin), .irq(wake_irq)
  );

  aclink_link_gate u_gate (
    .lowpwr(ctl_q[B_LOWPWR]), .sync_in(sync_in), .sdout_in(sdout_in),
    .sync_out(sync_out), .sdout_out(sdout_out)
  );

  assign link_reset_n = ctl_q[B_LINK];
  assign warm_reset   = ctl_q[B_WARM];
  assign rx_mic_sel   = ctl_q[B_MIC];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AD_EN)       bus_rdata = DATA_W'(ctl_q);
    else if (bus_addr == AD_RDY) bus_rdata = DATA_W'(rdy_q);
  end
endmodule

// File: rtl/aclink_ctrl_chk.sv
module aclink_ctrl_chk
  import aclink_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_hit,
  input logic              wr_dis_hit,
  input logic              rdy_clr_pulse,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_we,
  input ctl_t              ctl_q,
  input logic [N_CODEC-1:0] rdy_q,
  input logic              sync_out,
  input logic              sdout_out,
  input logic [N_SDIN-1:0] sdin,
  input logic              link_reset_n,
  input logic              wake_irq
);
  // R1
  after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!link_reset_n && ctl_q == '0));
  // R2
  set_link_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_hit && bus_wdata[B_LINK]) |=> link_reset_n);
  // R3
  clr_link_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dis_hit && bus_wdata[B_LINK]) |=> !link_reset_n);
  // R2
  zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata == '0) |=> $stable(ctl_q));
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[DATA_W-1:CTL_W] == '0));
  // R5
  rdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_clr_pulse |=> (rdy_q == '0));
  // R7
  lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[B_LOWPWR] |-> (!sync_out && !sdout_out));
  // R10
  wake_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (|sdin));
  // R11
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !wr_en_hit && !wr_dis_hit) |=> $stable(ctl_q));
endmodule

bind aclink_ctrl_reg aclink_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en_hit(wr_en_hit), .wr_dis_hit(wr_dis_hit),
  .rdy_clr_pulse(rdy_clr_pulse), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_we(bus_we), .ctl_q(ctl_q), .rdy_q(rdy_q),
  .sync_out(sync_out), .sdout_out(sdout_out), .sdin(sdin),
  .link_reset_n(link_reset_n), .wake_irq(wake_irq)
);

// File: tb/test_aclink_ctrl_reg.sv
module test_aclink_ctrl_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sync_in = 1'b0, sdout_in = 1'b0, sync_out, sdout_out;
  logic [1:0] sdin = '0, codec_rdy_in = '0;
  logic link_reset_n, warm_reset, rx_mic_sel, wake_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aclink_ctrl_reg i_aclink_ctrl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .sdout_in(sdout_in), .sync_out(sync_out), .sdout_out(sdout_out),
    .sdin(sdin), .codec_rdy_in(codec_rdy_in), .link_reset_n(link_reset_n),
    .warm_reset(warm_reset), .rx_mic_sel(rx_mic_sel), .wake_irq(wake_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // expected state model kept in the bench
  logic [4:0] model = '0;

  task automatic check_ports(input string req);
    logic [7:0] r;
    rd(4'd0, r);
    chk({req, " readback"}, r, {3'b0, model});
    chk({req, " R6 link_reset_n"}, {7'b0, link_reset_n}, {7'b0, model[0]});
    chk({req, " R9 warm_reset"}, {7'b0, warm_reset}, {7'b0, model[3]});
    chk({req, " R8 rx_mic_sel"}, {7'b0, rx_mic_sel}, {7'b0, model[4]});
  endtask

  task automatic t_reset;
    logic [7:0] r;
    model = '0;
    check_ports("R1");
    rd(4'd2, r);
    chk("R1 ready flags", r, 8'h00);
    sync_in = 1'b1; sdout_in = 1'b1; #1;
    chk("R1 passthrough", {6'b0, sync_out, sdout_out}, 8'h03);
    sync_in = 1'b0; sdout_in = 1'b0;
  endtask

  task automatic t_set_clear;
    wr(4'd0, 8'h01); model = 5'h01; check_ports("R2 set link");
    wr(4'd0, 8'h18); model = 5'h19; check_ports("R2 set warm+mic");
    wr(4'd0, 8'h00); check_ports("R2 zero write");
    wr(4'd1, 8'h08); model = 5'h11; check_ports("R3 clear warm");
    wr(4'd1, 8'h00); check_ports("R3 zero clear");
    wr(4'd1, 8'h1F); model = 5'h00; check_ports("R3 clear all");
  endtask

  task automatic t_reserved;
    logic [7:0] r;
    wr(4'd0, 8'hE0); rd(4'd0, r);
    chk("R4 reserved bits", r & 8'hE0, 8'h00);
    chk("R4 no set from high bits", r, 8'h00);
  endtask

  task automatic t_ready;
    logic [7:0] r;
    @(negedge clk); codec_rdy_in = 2'b01;
    @(negedge clk); codec_rdy_in = 2'b00;
    rd(4'd2, r); chk("R5 codec0 set", r, 8'h01);
    @(negedge clk); codec_rdy_in = 2'b10;
    @(negedge clk); codec_rdy_in = 2'b00;
    rd(4'd2, r); chk("R5 sticky both", r, 8'h03);
    wr(4'd0, 8'h00); rd(4'd2, r); chk("R5 bit5 zero no clear", r, 8'h03);
    @(negedge clk);
    bus_addr = 4'd0; bus_wdata = 8'h20; bus_we = 1'b1; codec_rdy_in = 2'b11;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; codec_rdy_in = 2'b00;
    rd(4'd2, r); chk("R5 clear wins", r, 8'h00);
    check_ports("R5 control untouched");
  endtask

  task automatic t_lowpwr;
    wr(4'd0, 8'h02); model = 5'h02;
    sync_in = 1'b1; sdout_in = 1'b1; #1;
    chk("R7 forced low", {6'b0, sync_out, sdout_out}, 8'h00);
    wr(4'd1, 8'h02); model = 5'h00; #1;
    chk("R7 released", {6'b0, sync_out, sdout_out}, 8'h03);
    sdout_in = 1'b0; #1;
    chk("R7 follows data", {6'b0, sync_out, sdout_out}, 8'h02);
    sync_in = 1'b0;
  endtask

  task automatic t_wake;
    sdin = 2'b01; #1;
    chk("R10 disabled", {7'b0, wake_irq}, 8'h00);
    wr(4'd0, 8'h04); model = 5'h04;
    sdin = 2'b00; #1; chk("R10 lines low", {7'b0, wake_irq}, 8'h00);
    sdin = 2'b10; #1; chk("R10 sdin1", {7'b0, wake_irq}, 8'h01);
    sdin = 2'b01; #1; chk("R10 sdin0", {7'b0, wake_irq}, 8'h01);
    wr(4'd1, 8'h04); model = 5'h00; #1;
    chk("R10 disable drops", {7'b0, wake_irq}, 8'h00);
    sdin = 2'b00;
  endtask

  task automatic t_decode;
    logic [7:0] r;
    wr(4'd0, 8'h11); model = 5'h11;
    wr(4'd2, 8'h1F); check_ports("R11 write addr2");
    wr(4'd7, 8'h1F); check_ports("R11 write addr7");
    wr(4'd5, 8'h1F); check_ports("R11 write addr5");
    rd(4'd1, r); chk("R11 read addr1", r, 8'h00);
    rd(4'd9, r); chk("R11 read addr9", r, 8'h00);
  endtask

  task automatic t_rereset;
    wr(4'd0, 8'h1F); model = 5'h1F; check_ports("R2 all set");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = '0; check_ports("R1 reset again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_reserved();
    t_ready();
    t_lowpwr();
    t_wake();
    t_decode();
    t_rereset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule